// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken. It keeps a short global record of the outcomes of the most recent branches, a history of `HIST_W` bits. It also keeps a table of `CTR_W`-bit saturating counters. The counter for a branch is selected by two things together: the recent outcome pattern and some low-order bits of the branch's word address. The same branch can therefore learn a different tendency for each pattern of preceding outcomes. The predicted direction is the top bit of the selected counter.

A front end presents a branch address on the lookup port. One cycle later it receives the predicted direction together with the history value that was used to form the index. When the branch resolves, the pipeline returns the address, that saved history and the real outcome on the update port. The addressed counter moves one step toward the outcome, and the outcome is shifted into the global history. With the default parameters (2 history bits, 10 address bits, 2-bit counters) the table holds 4096 counters.

Top module: `bp_corr_predictor`

## Requirements
- R1: While reset is applied and after it is released, the history is all zeros, every counter holds the weakly-not-taken value 2^(CTR_W-1)-1 (binary 01 for 2-bit counters), and `pred_valid`, `pred_taken` and `pred_hist` are 0. A counter trained before a reset predicts not taken after it.
- R2: A lookup taken at a clock edge raises `pred_valid` for exactly the following cycle. In that cycle `pred_taken` equals the most significant bit of the counter selected at the edge, and `pred_hist` equals the history held at the edge.
- R3: The table index is the concatenation {history, pc[ADDR_BITS+1:2]}, with the history in the upper bits. PC bits 1:0 have no effect on the index.
- R4: An update with outcome 1 increments the addressed counter and an update with outcome 0 decrements it. The count stops at 2^CTR_W-1 and at 0.
- R5: From a strongly-taken counter (11), one not-taken update leaves the prediction taken. A second consecutive not-taken update turns it to not taken.
- R6: An update addresses its counter with the history supplied on `upd_hist`, not with the current global history.
- R7: Each update shifts its outcome into history bit 0, moves every other bit up one place and drops the oldest bit. Without an update the history keeps its value.
- R8: When a lookup and an update occur at the same edge, the lookup returns the counter and history as they were before that update. A later lookup sees the update.
- R9: When there is no lookup, `pred_valid` is 0 and `pred_taken` and `pred_hist` keep their last values.
- R10: Two branch addresses that differ only in bits above ADDR_BITS+1 share the same counters (aliasing).
- R11: The same branch address under different history values uses separate counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lookup_valid | input | 1 | Request a prediction for `lookup_pc` |
| lookup_pc | input | PC_W | Address of the branch to predict |
| pred_valid | output | 1 | Prediction result present this cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used to form the prediction index |
| upd_valid | input | 1 | Resolved branch outcome present |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History that was returned at that branch's lookup |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
A prediction appears one clock after its lookup edge. The bench drives every request on a falling edge, lets one rising edge pass and samples `pred_valid`, `pred_taken` and `pred_hist` at the next falling edge. An update changes a counter and the history at the edge where it is sampled. Its effect is therefore observed through a lookup issued at the following falling edge, whose result is sampled one cycle after that. The same-edge case is checked the same way: the paired lookup must still show the old counter and the old history. Reset release passes through a two-stage synchroniser, so the bench waits several cycles after deasserting `rst_n` before it issues the first request.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // byte offset within an instruction word, never used for indexing
  localparam int WORD_OFS = 2;

  // widest counter the step helper supports
  localparam int STEP_W = 8;

  // one saturating step of a counter toward the resolved direction
  function automatic logic [STEP_W-1:0] sat_step(
    input logic [STEP_W-1:0] cur,
    input logic [STEP_W-1:0] top,
    input logic              up
  );
    logic [STEP_W-1:0] res;
    if (up) begin
      res = (cur == top) ? cur : cur + 1'b1;
    end else begin
      res = (cur == '0) ? cur : cur - 1'b1;
    end
    return res;
  endfunction

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W-1:0] hist_d;

  // newest outcome enters bit 0, the oldest bit falls off the top
  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      hist_d = HIST_W'({hist_q, bit_in});
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/bp_index_gen.sv
module bp_index_gen #(
  parameter int PC_W      = 32,
  parameter int HIST_W    = 2,
  parameter int ADDR_BITS = 10,
  localparam int IDX_W    = HIST_W + ADDR_BITS
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  import bp_pkg::*;

  logic [ADDR_BITS-1:0] pc_part;

  assign pc_part = pc[WORD_OFS +: ADDR_BITS];
  assign idx     = {hist, pc_part};

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  import bp_pkg::*;

  localparam int          TOP_I  = (1 << CTR_W) - 1;
  localparam int          WNT_I  = (1 << (CTR_W - 1)) - 1;
  localparam logic [CTR_W-1:0] RST_VAL = CTR_W'(WNT_I);

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] wr_val;
  logic             rd_msb_d;

  // next value of the counter being trained
  always_comb begin
    wr_val = CTR_W'(sat_step(STEP_W'(ctr_q[wr_idx]), STEP_W'(TOP_I), wr_taken));
  end

  // registered read, reads the table before any same-edge write
  always_comb begin
    rd_msb_d = rd_msb_q;
    if (rd_en) begin
      rd_msb_d = ctr_q[rd_idx][CTR_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctr_q[i] <= RST_VAL;
      end
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_msb_q <= 1'b0;
    end else begin
      rd_msb_q <= rd_msb_d;
    end
  end

endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor #(
  parameter int PC_W      = 32,
  parameter int HIST_W    = 2,
  parameter int ADDR_BITS = 10,
  parameter int CTR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_valid,
  input  logic [PC_W-1:0]   lookup_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);

  localparam int IDX_W = HIST_W + ADDR_BITS;

  logic              rst_ni;
  logic [HIST_W-1:0] ghr_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic              pv_q;
  logic              pv_d;
  logic [HIST_W-1:0] ph_q;
  logic [HIST_W-1:0] ph_d;

  bp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist_q   (ghr_q)
  );

  bp_index_gen #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS)) u_rd_idx (
    .pc   (lookup_pc),
    .hist (ghr_q),
    .idx  (rd_idx)
  );

  bp_index_gen #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS)) u_wr_idx (
    .pc   (upd_pc),
    .hist (upd_hist),
    .idx  (wr_idx)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_tab (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .rd_en    (lookup_valid),
    .rd_idx   (rd_idx),
    .rd_msb_q (pred_taken),
    .wr_en    (upd_valid),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken)
  );

  // response qualifiers and the history snapshot handed back to the caller
  always_comb begin
    pv_d = lookup_valid;
    ph_d = ph_q;
    if (lookup_valid) begin
      ph_d = ghr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= 1'b0;
      ph_q <= '0;
    end else begin
      pv_q <= pv_d;
      ph_q <= ph_d;
    end
  end

  assign pred_valid = pv_q;
  assign pred_hist  = ph_q;

endmodule

// File: rtl/bp_corr_checker.sv
module bp_corr_checker #(
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              lookup_valid,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] ghr_q,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_ni |-> (ghr_q == '0 && !pred_valid && !pred_taken)); // R1

  AST_PRED_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_ni) lookup_valid |=> pred_valid); // R2

  AST_PRED_HIST_SNAP: assert property (@(posedge clk) disable iff (!rst_ni) lookup_valid |=> pred_hist == $past(ghr_q)); // R2

  AST_PRED_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_ni) !lookup_valid |=> !pred_valid); // R9

  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_ni) !lookup_valid |=> ($stable(pred_taken) && $stable(pred_hist))); // R9

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_ni) !upd_valid |=> $stable(ghr_q)); // R7

  AST_HIST_LSB: assert property (@(posedge clk) disable iff (!rst_ni) upd_valid |=> ghr_q[0] == $past(upd_taken)); // R7

  if (HIST_W > 1) begin : g_shift
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_ni) upd_valid |=> ghr_q[HIST_W-1:1] == $past(ghr_q[HIST_W-2:0])); // R7
  end

endmodule

bind bp_corr_predictor bp_corr_checker #(.HIST_W(HIST_W)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .lookup_valid (lookup_valid),
  .upd_valid    (upd_valid),
  .upd_taken    (upd_taken),
  .ghr_q        (ghr_q),
  .pred_valid   (pred_valid),
  .pred_taken   (pred_taken),
  .pred_hist    (pred_hist)
);

// File: tb/sim_bp_corr_predictor.sv
module sim_bp_corr_predictor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lookup_valid;
  logic [31:0] lookup_pc;
  logic        pred_valid;
  logic        pred_taken;
  logic [1:0]  pred_hist;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic [1:0]  upd_hist;
  logic        upd_taken;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bp_corr_predictor u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .lookup_pc    (lookup_pc),
    .pred_valid   (pred_valid),
    .pred_taken   (pred_taken),
    .pred_hist    (pred_hist),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_hist     (upd_hist),
    .upd_taken    (upd_taken)
  );

  // step: {is_lookup, pc, hist, taken, exp_pred, exp_hist}
  localparam int NSTEP = 18;
  localparam logic [38:0] STEPS [NSTEP] = '{
    {1'b1, 32'h0000_0100, 2'b00, 1'b0, 1'b0, 2'b00}, // R1 R2 fresh counter weak not taken
    {1'b0, 32'h0000_0100, 2'b00, 1'b1, 1'b0, 2'b00}, // R4 01->10
    {1'b1, 32'h0000_0100, 2'b00, 1'b0, 1'b0, 2'b01}, // R11 history 01 uses its own counter
    {1'b0, 32'h0000_0100, 2'b00, 1'b1, 1'b0, 2'b00}, // R4 10->11
    {1'b0, 32'h0000_0100, 2'b00, 1'b1, 1'b0, 2'b00}, // R4 saturate high
    {1'b0, 32'h0000_0100, 2'b01, 1'b0, 1'b0, 2'b00}, // R6 supplied history 01, ghr 11
    {1'b0, 32'h0000_0100, 2'b01, 1'b0, 1'b0, 2'b00}, // R4 saturate low
    {1'b1, 32'h0000_0100, 2'b00, 1'b0, 1'b1, 2'b00}, // R4 strongly taken
    {1'b0, 32'h0000_0100, 2'b00, 1'b0, 1'b0, 2'b00}, // R5 first miss
    {1'b1, 32'h0000_0100, 2'b00, 1'b0, 1'b1, 2'b00}, // R5 still taken
    {1'b0, 32'h0000_0100, 2'b00, 1'b0, 1'b0, 2'b00}, // R5 second miss
    {1'b1, 32'h0000_0100, 2'b00, 1'b0, 1'b0, 2'b00}, // R5 flipped
    {1'b0, 32'h0000_0100, 2'b01, 1'b1, 1'b0, 2'b00}, // R6 00->01
    {1'b1, 32'h0000_0100, 2'b00, 1'b0, 1'b0, 2'b01}, // R4 R6 low saturation held
    {1'b0, 32'h0000_4100, 2'b01, 1'b1, 1'b0, 2'b00}, // R10 alias trains 01 entry
    {1'b1, 32'h0000_0102, 2'b00, 1'b0, 1'b0, 2'b11}, // R3 offset bits ignored
    {1'b0, 32'h0000_4100, 2'b11, 1'b1, 1'b0, 2'b00}, // R10 alias trains 11 entry
    {1'b1, 32'h0000_0103, 2'b00, 1'b0, 1'b1, 2'b11}  // R3 R10 shared counter seen
  };

  function automatic string step_req(input int s);
    case (s)
      0:             return "R1/R2";
      2:             return "R11";
      5, 12:         return "R6";
      8, 9, 10, 11:  return "R5";
      14, 16:        return "R10";
      15:            return "R3";
      17:            return "R3/R10";
      default:       return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_all();
    lookup_valid = 1'b0;
    lookup_pc    = '0;
    upd_valid    = 1'b0;
    upd_pc       = '0;
    upd_hist     = '0;
    upd_taken    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // returns results sampled one falling edge after the lookup edge
  task automatic do_lookup(input logic [31:0] pc, output logic v,
                           output logic t, output logic [1:0] h);
    lookup_valid = 1'b1;
    lookup_pc    = pc;
    @(negedge clk);
    lookup_valid = 1'b0;
    v = pred_valid;
    t = pred_taken;
    h = pred_hist;
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [1:0] hist,
                           input logic tk);
    upd_valid = 1'b1;
    upd_pc    = pc;
    upd_hist  = hist;
    upd_taken = tk;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic       v;
    logic       t;
    logic [1:0] h;
    logic [38:0] st;
    rst_n = 1'b0;
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 outputs after reset
    chk(pred_valid == 1'b0, "R1", "pred_valid after reset", pred_valid, 0);
    chk(pred_taken == 1'b0, "R1", "pred_taken after reset", pred_taken, 0);
    chk(pred_hist == 2'b00, "R1", "pred_hist after reset", pred_hist, 0);

    for (int s = 0; s < NSTEP; s++) begin
      st = STEPS[s];
      if (st[38]) begin
        do_lookup(st[37:6], v, t, h);
        chk(v == 1'b1, step_req(s), $sformatf("step %0d valid", s), v, 1);
        chk(t == st[2], step_req(s), $sformatf("step %0d taken", s), t, st[2]);
        chk(h == st[1:0], step_req(s), $sformatf("step %0d hist", s), h, st[1:0]);
      end else begin
        do_update(st[37:6], st[5:4], st[3]);
      end
    end

    // R9 outputs hold while idle, valid low
    repeat (3) @(negedge clk);
    chk(pred_valid == 1'b0, "R9", "valid while idle", pred_valid, 0);
    chk(pred_taken == 1'b1, "R9", "taken held while idle", pred_taken, 1);
    chk(pred_hist == 2'b11, "R9", "hist held while idle", pred_hist, 3);

    // R8 lookup and update at the same edge, ghr is 11
    lookup_valid = 1'b1;
    lookup_pc    = 32'h0000_0200;
    upd_valid    = 1'b1;
    upd_pc       = 32'h0000_0200;
    upd_hist     = 2'b11;
    upd_taken    = 1'b1;
    @(negedge clk);
    idle_all();
    chk(pred_taken == 1'b0, "R8", "same-edge lookup sees old counter", pred_taken, 0);
    chk(pred_hist == 2'b11, "R8", "same-edge lookup sees old history", pred_hist, 3);
    do_lookup(32'h0000_0200, v, t, h);
    chk(t == 1'b1, "R8", "later lookup sees update", t, 1);
    chk(pred_valid == 1'b1, "R2", "valid one cycle after lookup", pred_valid, 1);
    @(negedge clk);
    chk(pred_valid == 1'b0, "R2", "valid lasts one cycle", pred_valid, 0);

    // R1 trained counter returns to weak not taken across reset
    do_update(32'h0000_0300, 2'b00, 1'b1);
    do_update(32'h0000_0300, 2'b00, 1'b1);
    do_update(32'h0000_0000, 2'b00, 1'b0);
    do_update(32'h0000_0000, 2'b00, 1'b0);
    do_lookup(32'h0000_0300, v, t, h);
    chk(t == 1'b1 && h == 2'b00, "R1", "trained before reset", {t, h}, 4);
    do_reset();
    chk(pred_hist == 2'b00 && pred_taken == 1'b0, "R1", "outputs cleared by reset", {pred_taken, pred_hist}, 0);
    do_lookup(32'h0000_0300, v, t, h);
    chk(t == 1'b0, "R1", "counter reset to weak not taken", t, 0);

    // R7 history shift sequence 1,0,1,1,0
    do_update(32'h0000_0500, 2'b00, 1'b1);
    do_lookup(32'h0000_0500, v, t, h);
    chk(h == 2'b01, "R7", "history after 1", h, 1);
    do_update(32'h0000_0500, 2'b00, 1'b0);
    do_lookup(32'h0000_0500, v, t, h);
    chk(h == 2'b10, "R7", "history after 1,0", h, 2);
    do_update(32'h0000_0500, 2'b00, 1'b1);
    do_update(32'h0000_0500, 2'b00, 1'b1);
    do_lookup(32'h0000_0500, v, t, h);
    chk(h == 2'b11, "R7", "history after 1,0,1,1", h, 3);
    do_update(32'h0000_0500, 2'b00, 1'b0);
    do_lookup(32'h0000_0500, v, t, h);
    chk(h == 2'b10, "R7", "history after trailing 0", h, 2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule